// File: doc/BRIEF.md
# Dual-Pipe Issue Steering Unit

This unit sits between decode and execute in a core with two unequal execution pipes. One pipe, A, carries memory traffic. The other, B, carries control flow and long-latency arithmetic. Each cycle the unit accepts up to two decoded instructions in program order. Each instruction is tagged with a 3-bit operation class. For every slot the unit decides whether the instruction issues and which pipe or pipes it claims. A slot that cannot issue raises a stall.

The unit also guards two execution resources that stay occupied long after issue: an integer divider and a floating-point divide/square-root unit. After a divide issues, a countdown holds off any later divide of the same kind until the resource is free. Every other class keeps flowing. A synchronous flush empties both countdowns.

The decision is made from the inputs presented in a cycle and from the current countdown state. The results appear on registered outputs one clock later. The countdowns change at the same edge as the decision.

Top module: `dual_issue_steer`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is zero.
- R2: Class code 1 (memory and register-file crossing moves) may only issue on pipe A. Its claim is 2'b01, where claim bit 0 is pipe A and bit 1 is pipe B.
- R3: Class codes 2 and 7 (branches, jumps, multiplies, floating-point operations) may only issue on pipe B, claim 2'b10.
- R4: Class code 0 (simple integer work) takes pipe A if it is free and otherwise pipe B. When both slots hold code 0, slot 0 claims A and slot 1 claims B.
- R5: Class code 3 claims both pipes (claim 2'b11), so no other instruction issues in the same cycle.
- R6: Slot 1 issues only if slot 0 issues in the same cycle and a legal pipe is left for slot 1. The two claims never overlap.
- R7: Class code 4 (integer divide) issues on pipe B. Once it issues, any integer divide offered in the next 15 cycles stalls, and one offered in the 16th cycle after issue may issue.
- R8: Class code 5 (single-precision FP divide or square root) issues on pipe B. It keeps the FP divide unit busy, so FP divides (codes 5 and 6) stall for the next 26 cycles.
- R9: Class code 6 (double-precision FP divide or square root) issues on pipe B. It keeps the FP divide unit busy for the next 55 cycles.
- R10: A busy divide unit blocks only divides that need that unit. Other classes, and divides for the other unit, still issue.
- R11: Flush clears both busy countdowns. The decision taken in the flush cycle still sees the old state, and a divide offered in the next cycle can issue.
- R12: The outputs show each cycle's decision one clock later. The stall output is high exactly when some valid slot did not issue, and a slot that did not issue shows claim 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_flush | input | 1 | Clears both divide busy countdowns |
| i_vld | input | 2 | Per-slot instruction valid, bit 0 is the older slot |
| i_cls0 | input | 3 | Operation class of slot 0 |
| i_cls1 | input | 3 | Operation class of slot 1 |
| o_vld | output | 2 | Per-slot issue flag, registered |
| o_claim0 | output | 2 | Pipe claim of slot 0 (bit 0 = A, bit 1 = B) |
| o_claim1 | output | 2 | Pipe claim of slot 1 |
| o_stall | output | 1 | Some valid slot was held back |

## Verification
The bench runs every pairing that puts the two slots on the same single pipe. A unit that lets slot 1 take a pipe already held by slot 0 would show overlapping claims. The bench also presents a younger instruction behind an older one that has stalled, and a unit that issues out of order would raise slot 1 alone. The divide windows are probed in the last blocked cycle and the first free cycle. An off-by-one countdown either lets a divide through one cycle early or holds it one cycle too long. The remaining cases are a flush that lands mid-window, where a wrong unit either misses the clear or lets it take effect in the flush cycle, and divides for the two different units issued back to back, which a unit that shares one countdown would wrongly stall.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [2:0] {
    OP_EITHER = 3'd0,
    OP_APIPE  = 3'd1,
    OP_BPIPE  = 3'd2,
    OP_DUAL   = 3'd3,
    OP_IDIV   = 3'd4,
    OP_FDIVS  = 3'd5,
    OP_FDIVD  = 3'd6,
    OP_BALT   = 3'd7
  } op_cls_e;

  localparam logic [1:0] CLAIM_NONE = 2'b00;
  localparam logic [1:0] CLAIM_A    = 2'b01;
  localparam logic [1:0] CLAIM_B    = 2'b10;
  localparam logic [1:0] CLAIM_AB   = 2'b11;
endpackage

// File: rtl/steer_busy_ctr.sv
module steer_busy_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_clr,
  input  logic             i_load,
  input  logic [CNT_W-1:0] i_load_val,
  output logic             o_busy
);
  logic [CNT_W-1:0] cnt_q;

  // Clear wins over a load in the same cycle; otherwise count down to idle.
  always_ff @(posedge clk) begin
    if (rst || i_clr) begin
      cnt_q <= '0;
    end else if (i_load) begin
      cnt_q <= i_load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign o_busy = (cnt_q != '0);
endmodule

// File: rtl/steer_slot_pick.sv
module steer_slot_pick
  import steer_pkg::*;
(
  input  logic       i_vld,
  input  logic [2:0] i_cls,
  input  logic [1:0] i_free,
  input  logic       i_idiv_ok,
  input  logic       i_fdiv_ok,
  output logic       o_go,
  output logic [1:0] o_claim,
  output logic       o_idiv,
  output logic       o_fdivs,
  output logic       o_fdivd
);
  op_cls_e    cls;
  logic [1:0] want;
  logic       unit_ok;

  assign cls = op_cls_e'(i_cls);

  always_comb begin
    want    = CLAIM_NONE;
    unit_ok = 1'b1;
    unique case (cls)
      OP_EITHER: begin
        if (i_free[0])      want = CLAIM_A;
        else if (i_free[1]) want = CLAIM_B;
        else                want = CLAIM_NONE;
      end
      OP_APIPE:             want = CLAIM_A;
      OP_BPIPE, OP_BALT:    want = CLAIM_B;
      OP_DUAL:              want = CLAIM_AB;
      OP_IDIV: begin
        want    = CLAIM_B;
        unit_ok = i_idiv_ok;
      end
      OP_FDIVS, OP_FDIVD: begin
        want    = CLAIM_B;
        unit_ok = i_fdiv_ok;
      end
      default:              want = CLAIM_B;
    endcase
  end

  assign o_go    = i_vld && (want != CLAIM_NONE) && ((want & ~i_free) == 2'b00) && unit_ok;
  assign o_claim = o_go ? want : CLAIM_NONE;
  assign o_idiv  = o_go && (cls == OP_IDIV);
  assign o_fdivs = o_go && (cls == OP_FDIVS);
  assign o_fdivd = o_go && (cls == OP_FDIVD);
endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
  import steer_pkg::*;
#(
  parameter int IDIV_BUSY  = 15,
  parameter int FDIVS_BUSY = 26,
  parameter int FDIVD_BUSY = 55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       i_flush,
  input  logic [1:0] i_vld,
  input  logic [2:0] i_cls0,
  input  logic [2:0] i_cls1,
  output logic [1:0] o_vld,
  output logic [1:0] o_claim0,
  output logic [1:0] o_claim1,
  output logic       o_stall
);
  localparam int NSLOT    = 2;
  localparam int MAX_FDIV = (FDIVS_BUSY > FDIVD_BUSY) ? FDIVS_BUSY : FDIVD_BUSY;
  localparam int MAX_BUSY = (IDIV_BUSY > MAX_FDIV) ? IDIV_BUSY : MAX_FDIV;
  localparam int CNT_W    = $clog2(MAX_BUSY + 1);
  localparam logic [CNT_W-1:0] IDIV_LD  = CNT_W'(IDIV_BUSY);
  localparam logic [CNT_W-1:0] FDIVS_LD = CNT_W'(FDIVS_BUSY);
  localparam logic [CNT_W-1:0] FDIVD_LD = CNT_W'(FDIVD_BUSY);

  logic [2:0]       cls_s   [NSLOT];
  logic [1:0]       free_s  [NSLOT];
  logic [1:0]       claim_s [NSLOT];
  logic             iok_s   [NSLOT];
  logic             fok_s   [NSLOT];
  logic [NSLOT-1:0] go_v, idiv_v, fdivs_v, fdivd_v;
  logic             idiv_busy, fdiv_busy;

  assign cls_s[0] = i_cls0;
  assign cls_s[1] = i_cls1;

  // Older slot chooses first; each younger slot sees what is left.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == 0) begin : g_head
      assign free_s[s] = CLAIM_AB;
      assign iok_s[s]  = !idiv_busy;
      assign fok_s[s]  = !fdiv_busy;
    end else begin : g_tail
      assign free_s[s] = go_v[s-1] ? (free_s[s-1] & ~claim_s[s-1]) : CLAIM_NONE;
      assign iok_s[s]  = iok_s[s-1] && !idiv_v[s-1];
      assign fok_s[s]  = fok_s[s-1] && !fdivs_v[s-1] && !fdivd_v[s-1];
    end

    steer_slot_pick u_pick (
      .i_vld     (i_vld[s]),
      .i_cls     (cls_s[s]),
      .i_free    (free_s[s]),
      .i_idiv_ok (iok_s[s]),
      .i_fdiv_ok (fok_s[s]),
      .o_go      (go_v[s]),
      .o_claim   (claim_s[s]),
      .o_idiv    (idiv_v[s]),
      .o_fdivs   (fdivs_v[s]),
      .o_fdivd   (fdivd_v[s])
    );
  end

  steer_busy_ctr #(.CNT_W(CNT_W)) u_idiv_ctr (
    .clk        (clk),
    .rst        (rst),
    .i_clr      (i_flush),
    .i_load     (|idiv_v),
    .i_load_val (IDIV_LD),
    .o_busy     (idiv_busy)
  );

  steer_busy_ctr #(.CNT_W(CNT_W)) u_fdiv_ctr (
    .clk        (clk),
    .rst        (rst),
    .i_clr      (i_flush),
    .i_load     ((|fdivs_v) || (|fdivd_v)),
    .i_load_val ((|fdivd_v) ? FDIVD_LD : FDIVS_LD),
    .o_busy     (fdiv_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld    <= '0;
      o_claim0 <= CLAIM_NONE;
      o_claim1 <= CLAIM_NONE;
      o_stall  <= 1'b0;
    end else begin
      o_vld    <= go_v;
      o_claim0 <= claim_s[0];
      o_claim1 <= claim_s[1];
      o_stall  <= |(i_vld & ~go_v);
    end
  end
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
  parameter int IDIV_BUSY  = 15,
  parameter int FDIVS_BUSY = 26,
  parameter int FDIVD_BUSY = 55
) (
  input logic       clk,
  input logic       rst,
  input logic       i_flush,
  input logic [1:0] i_vld,
  input logic [2:0] i_cls0,
  input logic [2:0] i_cls1,
  input logic [1:0] o_vld,
  input logic [1:0] o_claim0,
  input logic [1:0] o_claim1,
  input logic       o_stall
);
  logic [2:0] q_cls0, q_cls1;
  logic [1:0] q_vld;
  logic       q_flush, q_live;
  int         win_i, win_f;
  logic       idiv_iss, fdiv_iss, fdivd_iss;

  always_ff @(posedge clk) begin
    q_cls0  <= i_cls0;
    q_cls1  <= i_cls1;
    q_vld   <= i_vld;
    q_flush <= i_flush;
    q_live  <= !rst;
  end

  assign idiv_iss  = (o_vld[0] && q_cls0 == 3'd4) || (o_vld[1] && q_cls1 == 3'd4);
  assign fdivd_iss = (o_vld[0] && q_cls0 == 3'd6) || (o_vld[1] && q_cls1 == 3'd6);
  assign fdiv_iss  = fdivd_iss || (o_vld[0] && q_cls0 == 3'd5) || (o_vld[1] && q_cls1 == 3'd5);

  // Window counters rebuilt from the ports, one cycle behind the decisions.
  always_ff @(posedge clk) begin
    if (rst || q_flush) win_i <= 0;
    else if (idiv_iss)  win_i <= IDIV_BUSY;
    else if (win_i > 0) win_i <= win_i - 1;
  end

  always_ff @(posedge clk) begin
    if (rst || q_flush) win_f <= 0;
    else if (fdiv_iss)  win_f <= fdivd_iss ? FDIVD_BUSY : FDIVS_BUSY;
    else if (win_f > 0) win_f <= win_f - 1;
  end

  assert_claim_disjoint_R6: assert property (@(posedge clk) disable iff (rst)
    (o_claim0 & o_claim1) == 2'b00);

  assert_slot1_needs_slot0_R6: assert property (@(posedge clk) disable iff (rst)
    o_vld[1] |-> o_vld[0]);

  assert_claim_matches_vld_R12: assert property (@(posedge clk) disable iff (rst)
    ((o_claim0 != 2'b00) == o_vld[0]) && ((o_claim1 != 2'b00) == o_vld[1]));

  assert_apipe_on_a_R2: assert property (@(posedge clk) disable iff (rst)
    (o_vld[0] && q_cls0 == 3'd1) |-> o_claim0 == 2'b01);

  assert_bpipe_on_b_R3: assert property (@(posedge clk) disable iff (rst)
    (o_vld[0] && (q_cls0 == 3'd2 || q_cls0 == 3'd7)) |-> o_claim0 == 2'b10);

  assert_dual_alone_R5: assert property (@(posedge clk) disable iff (rst)
    (o_vld[0] && q_cls0 == 3'd3) |-> (o_claim0 == 2'b11 && !o_vld[1]));

  assert_idiv_window_R7: assert property (@(posedge clk) disable iff (rst)
    idiv_iss |-> win_i == 0);

  assert_fdiv_window_R8: assert property (@(posedge clk) disable iff (rst)
    fdiv_iss |-> win_f == 0);

  assert_stall_flag_R12: assert property (@(posedge clk) disable iff (rst)
    q_live |-> (o_stall == |(q_vld & ~o_vld)));
endmodule

bind dual_issue_steer steer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .i_flush  (i_flush),
  .i_vld    (i_vld),
  .i_cls0   (i_cls0),
  .i_cls1   (i_cls1),
  .o_vld    (o_vld),
  .o_claim0 (o_claim0),
  .o_claim1 (o_claim1),
  .o_stall  (o_stall)
);

// File: tb/dual_issue_steer_tb.sv
module dual_issue_steer_tb;
  localparam logic [2:0] E = 3'd0, A = 3'd1, B = 3'd2, D = 3'd3,
                         ID = 3'd4, FS = 3'd5, FD = 3'd6, B7 = 3'd7;
  localparam logic [1:0] NA = 2'b00, PA = 2'b01, PB = 2'b10, PAB = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       i_flush = 1'b0;
  logic [1:0] i_vld = 2'b00;
  logic [2:0] i_cls0 = 3'd0, i_cls1 = 3'd0;
  logic [1:0] o_vld, o_claim0, o_claim1;
  logic       o_stall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         due;
    logic [1:0] vld;
    logic [1:0] c0;
    logic [1:0] c1;
    logic       stall;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  dual_issue_steer u_dut (
    .clk(clk), .rst(rst), .i_flush(i_flush), .i_vld(i_vld),
    .i_cls0(i_cls0), .i_cls1(i_cls1), .o_vld(o_vld),
    .o_claim0(o_claim0), .o_claim1(o_claim1), .o_stall(o_stall)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Drive one cycle of stimulus and queue the outputs it must produce.
  task automatic step(input logic [1:0] v, input logic [2:0] c0, input logic [2:0] c1,
                      input logic fl, input logic [1:0] ev, input logic [1:0] ec0,
                      input logic [1:0] ec1, input logic es, input string tag);
    exp_t e;
    @(negedge clk);
    i_vld = v; i_cls0 = c0; i_cls1 = c1; i_flush = fl;
    e.due = cyc + 1; e.vld = ev; e.c0 = ec0; e.c1 = ec1; e.stall = es; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare the decision registered at the edge before this negedge.
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (o_vld !== e.vld || o_claim0 !== e.c0 || o_claim1 !== e.c1 || o_stall !== e.stall) begin
        errors++;
        $display("FAIL %s: got vld=%b c0=%b c1=%b stall=%b, expected vld=%b c0=%b c1=%b stall=%b",
                 e.tag, o_vld, o_claim0, o_claim1, o_stall, e.vld, e.c0, e.c1, e.stall);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    i_vld = 2'b11;
    repeat (3) @(negedge clk);
    checks++;
    if (o_vld !== 2'b00 || o_claim0 !== NA || o_claim1 !== NA || o_stall !== 1'b0) begin
      errors++;
      $display("FAIL R1: got vld=%b c0=%b c1=%b stall=%b, expected all zero",
               o_vld, o_claim0, o_claim1, o_stall);
    end
    rst = 1'b0;
    i_vld = 2'b00;
    step(2'b00, E, E, 0, 2'b00, NA, NA, 0, "R1 first cycle");

    // Pipe steering by class.
    step(2'b11, E,  E, 0, 2'b11, PA, PB, 0, "R4 either+either");
    step(2'b11, A,  E, 0, 2'b11, PA, PB, 0, "R2 apipe+either");
    step(2'b11, B,  E, 0, 2'b11, PB, PA, 0, "R3 bpipe+either");
    step(2'b11, B7, E, 0, 2'b11, PB, PA, 0, "R3 code7+either");
    step(2'b11, E,  A, 0, 2'b01, PA, NA, 1, "R6 either then apipe");
    step(2'b11, A,  A, 0, 2'b01, PA, NA, 1, "R2 apipe pair");
    step(2'b11, B,  B, 0, 2'b01, PB, NA, 1, "R3 bpipe pair");
    step(2'b11, A,  B, 0, 2'b11, PA, PB, 0, "R6 apipe+bpipe");
    step(2'b01, D,  E, 0, 2'b01, PAB, NA, 0, "R5 dual alone");
    step(2'b11, D,  E, 0, 2'b01, PAB, NA, 1, "R5 dual then either");
    step(2'b11, E,  D, 0, 2'b01, PA, NA, 1, "R5 either then dual");
    step(2'b10, E,  E, 0, 2'b00, NA, NA, 1, "R6 slot1 without slot0");
    step(2'b00, E,  E, 0, 2'b00, NA, NA, 0, "R12 idle");

    // Integer divider window.
    step(2'b01, ID, E, 0, 2'b01, PB, NA, 0, "R7 idiv issue");
    for (int k = 1; k <= 15; k++)
      step(2'b01, ID, E, 0, 2'b00, NA, NA, 1, "R7 idiv blocked");
    step(2'b01, ID, E, 0, 2'b01, PB, NA, 0, "R7 idiv free at 16");
    step(2'b11, B,  E, 0, 2'b11, PB, PA, 0, "R10 bpipe during idiv window");
    step(2'b11, E,  ID, 0, 2'b01, PA, NA, 1, "R7 slot1 idiv blocked");
    step(2'b01, ID, E, 1, 2'b00, NA, NA, 1, "R11 flush cycle still blocked");
    step(2'b01, ID, E, 0, 2'b01, PB, NA, 0, "R11 idiv after flush");

    // FP divide windows.
    step(2'b11, FS, E, 0, 2'b11, PB, PA, 0, "R10 fdivs while idiv busy");
    for (int k = 1; k <= 26; k++)
      step(2'b01, FD, E, 0, 2'b00, NA, NA, 1, "R8 fdiv blocked after single");
    step(2'b01, FD, E, 0, 2'b01, PB, NA, 0, "R9 fdivd free at 27");
    step(2'b01, ID, E, 0, 2'b01, PB, NA, 0, "R10 idiv while fdiv busy");
    for (int k = 2; k <= 55; k++)
      step(2'b01, FS, E, 0, 2'b00, NA, NA, 1, "R9 fdiv blocked after double");
    step(2'b01, FS, E, 0, 2'b01, PB, NA, 0, "R9 fdivs free at 56");
    step(2'b00, E,  E, 1, 2'b00, NA, NA, 0, "R11 flush idle");
    step(2'b01, FD, E, 0, 2'b01, PB, NA, 0, "R11 fdivd after flush");
    step(2'b11, ID, FS, 0, 2'b01, PB, NA, 1, "R6 two divides share pipe B");

    step(2'b00, E, E, 0, 2'b00, NA, NA, 0, "R12 drain");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: got %0d unchecked items, expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule